// File: doc/BRIEF.md
# Processor Interval Timer

This block keeps a signed 64-bit interval that counts down by one microsecond each time a shared microsecond tick arrives. The same tick steps the time-of-day clock, so both advance at exactly the same rate. The timer word has the time-of-day clock's format. The microsecond unit is the bit at position 51 counted from the MSB, which is weight 2^12 of the full word. Because the word is signed, the timer covers half the period of the clock.

Software writes an interval through a load strobe and reads the live value on a plain output. Reading never disturbs counting. The timer advances only while the processor is executing instructions or waiting. It holds still while the system is stopped.

The interrupt request is a level, not a pulse. It is high for as long as the value is negative and both the external-summary mask and the timer-subclass mask are set. Loading a positive value therefore withdraws a pending request at once.

The load port is a plain register-write strobe and is always accepted. No valid/ready handshake applies, because the block never back-pressures.

Top module: `proc_interval_timer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the timer value is zero and `irq_o` is low.
- R2: A tick in a cycle where the processor is operating and not stopped lowers the value by 2^12 (one microsecond) at the next clock edge. Cycles without a tick leave the value unchanged.
- R3: A tick while the processor is in the wait state (and not stopped) lowers the value by 2^12, the same as in R2.
- R4: While `cpu_stopped_i` is high, ticks have no effect even if operating or wait is also high. With neither operating nor wait high, ticks have no effect either.
- R5: A load places `load_value_i` in the timer at the next clock edge, with its low 12 bits forced to zero. The low 12 bits of the value are always zero.
- R6: When a load and a counting tick arrive in the same cycle, the loaded value is stored and that tick is discarded.
- R7: `irq_o` is high in exactly those cycles where bit 63 (the sign) of the value is 1 and both `ext_mask_i` and `timer_mask_i` are 1. It follows the masks in the same cycle without a clock edge, and it stays high across further ticks while the value remains negative.
- R8: Loading a non-negative value drops a pending `irq_o` from the next clock edge on.
- R9: A tick at the most negative value (0x8000_0000_0000_0000) wraps to the most positive step-aligned value (0x7FFF_FFFF_FFFF_F000), with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (initial program reset) |
| us_tick_i | input | 1 | One-cycle microsecond pulse shared with the time-of-day clock |
| cpu_operating_i | input | 1 | Processor is executing instructions, retry included |
| cpu_wait_i | input | 1 | Processor is in the wait state |
| cpu_stopped_i | input | 1 | System is stopped |
| load_i | input | 1 | Load strobe |
| load_value_i | input | 64 | Interval to load |
| timer_value_o | output | 64 | Current timer value |
| ext_mask_i | input | 1 | External-summary mask |
| timer_mask_i | input | 1 | Timer-subclass mask |
| irq_o | output | 1 | Interrupt request, a level |

## Verification
The bench builds the block with its defaults: a 64-bit word and the tick unit at bit 51. At these values the step is 0x1000 and the low 12 bits are visibly cleared on load. A load of the most negative word followed by a single tick exercises the full-width wrap, so no long count-down is needed. Starting from a small load of one unit, the bench also walks the value through zero into negative and toggles each mask against the live sign.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  // Decoded per-cycle action on the timer register.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } ptmr_act_e;

  // Processor state as seen by the timer.
  typedef struct packed {
    logic operating;
    logic waiting;
    logic stopped;
  } ptmr_cpu_t;
endpackage

// File: rtl/ptmr_run_gate.sv
module ptmr_run_gate
  import ptmr_pkg::*;
(
  input  logic      tick_i,
  input  logic      load_i,
  input  ptmr_cpu_t cpu_i,
  output ptmr_act_e act_o
);
  logic counting;

  // Counting runs while executing or waiting, never while stopped.
  assign counting = (cpu_i.operating | cpu_i.waiting) & ~cpu_i.stopped;

  always_comb begin
    if (load_i)                 act_o = ACT_LOAD;
    else if (tick_i && counting) act_o = ACT_STEP;
    else                        act_o = ACT_HOLD;
  end
endmodule

// File: rtl/ptmr_count_reg.sv
module ptmr_count_reg
  import ptmr_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int SHIFT  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptmr_act_e         act_i,
  input  logic [WORD_W-1:0] load_val_i,
  output logic [WORD_W-1:0] val_o
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(1) << SHIFT;

  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] cnt_q;

  generate
    if (SHIFT == 0) begin : g_full
      assign keep_mask = '1;
    end else begin : g_trunc
      assign keep_mask = {{(WORD_W-SHIFT){1'b1}}, {SHIFT{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case (act_i)
        ACT_LOAD: cnt_q <= load_val_i & keep_mask;
        ACT_STEP: cnt_q <= cnt_q - STEP;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign val_o = cnt_q;
endmodule

// File: rtl/ptmr_irq_gate.sv
module ptmr_irq_gate (
  input  logic sign_i,
  input  logic ext_mask_i,
  input  logic sub_mask_i,
  output logic irq_o
);
  // Level request: held for as long as the value stays negative.
  assign irq_o = sign_i & ext_mask_i & sub_mask_i;
endmodule

// File: rtl/proc_interval_timer.sv
module proc_interval_timer
  import ptmr_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int TICK_POS = 51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick_i,
  input  logic              cpu_operating_i,
  input  logic              cpu_wait_i,
  input  logic              cpu_stopped_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_value_i,
  output logic [WORD_W-1:0] timer_value_o,
  input  logic              ext_mask_i,
  input  logic              timer_mask_i,
  output logic              irq_o
);
  localparam int SHIFT = WORD_W - 1 - TICK_POS;

  ptmr_cpu_t cpu;
  ptmr_act_e act;

  assign cpu = '{operating: cpu_operating_i, waiting: cpu_wait_i, stopped: cpu_stopped_i};

  ptmr_run_gate u_gate (
    .tick_i (us_tick_i),
    .load_i (load_i),
    .cpu_i  (cpu),
    .act_o  (act)
  );

  ptmr_count_reg #(.WORD_W(WORD_W), .SHIFT(SHIFT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (act),
    .load_val_i (load_value_i),
    .val_o      (timer_value_o)
  );

  ptmr_irq_gate u_irq (
    .sign_i     (timer_value_o[WORD_W-1]),
    .ext_mask_i (ext_mask_i),
    .sub_mask_i (timer_mask_i),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int WORD_W   = 64,
  parameter int TICK_POS = 51
) (
  input logic              clk,
  input logic              rst_n,
  input logic              us_tick_i,
  input logic              cpu_operating_i,
  input logic              cpu_wait_i,
  input logic              cpu_stopped_i,
  input logic              load_i,
  input logic [WORD_W-1:0] load_value_i,
  input logic [WORD_W-1:0] timer_value_o,
  input logic              ext_mask_i,
  input logic              timer_mask_i,
  input logic              irq_o
);
  localparam int SHIFT = WORD_W - 1 - TICK_POS;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(1) << SHIFT;
  localparam logic [WORD_W-1:0] LOW_MASK = STEP - WORD_W'(1);

  logic may_count;
  assign may_count = us_tick_i & (cpu_operating_i | cpu_wait_i) & ~cpu_stopped_i;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (timer_value_o == '0));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && may_count) |=> (timer_value_o == $past(timer_value_o) - STEP));

  // R4
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !may_count) |=> $stable(timer_value_o));

  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (timer_value_o == ($past(load_value_i) & ~LOW_MASK)));

  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((timer_value_o & LOW_MASK) == '0));

  // R7
  irq_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_value_o[WORD_W-1] |-> !irq_o);

  // R7
  irq_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_value_o[WORD_W-1] && ext_mask_i && timer_mask_i) |-> irq_o);

  // R8
  irq_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !load_value_i[WORD_W-1]) |=> !irq_o);
endmodule

bind proc_interval_timer ptmr_checker #(.WORD_W(WORD_W), .TICK_POS(TICK_POS)) u_chk (.*);

// File: tb/sim_proc_interval_timer.sv
`timescale 1ns/1ps
module sim_proc_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        op = 1'b0;
  logic        wt = 1'b0;
  logic        stp = 1'b0;
  logic        ld = 1'b0;
  logic [63:0] ldv = '0;
  logic [63:0] val;
  logic        emask = 1'b0;
  logic        smask = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  proc_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .us_tick_i(tick),
    .cpu_operating_i(op), .cpu_wait_i(wt), .cpu_stopped_i(stp),
    .load_i(ld), .load_value_i(ldv), .timer_value_o(val),
    .ext_mask_i(emask), .timer_mask_i(smask), .irq_o(irq)
  );

  task automatic chk_v(string req, logic [63:0] exp);
    total++;
    if (val !== exp) begin
      bad++;
      $display("FAIL %s value act=%h exp=%h", req, val, exp);
    end
  endtask

  task automatic chk_i(string req, logic exp);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", req, irq, exp);
    end
  endtask

  // One clock: inputs set by caller after a negedge, edge passes, pulses clear.
  task automatic cyc();
    @(negedge clk);
    tick = 1'b0;
    ld = 1'b0;
  endtask

  task automatic do_load(logic [63:0] v);
    ld = 1'b1; ldv = v; cyc();
  endtask

  task automatic t_reset();
    emask = 1'b1; smask = 1'b1; op = 1'b1; tick = 1'b1;
    @(negedge clk);
    chk_v("R1", 64'h0); chk_i("R1", 1'b0);
    rst_n = 1'b1; tick = 1'b0;
    cyc();
    chk_v("R1", 64'h0); chk_i("R1", 1'b0);
    emask = 1'b0; smask = 1'b0; op = 1'b0;
  endtask

  task automatic t_load();
    do_load(64'h0123_4567_89AB_CDEF);
    chk_v("R5", 64'h0123_4567_89AB_C000);
    do_load(64'h0000_0000_0000_0FFF);
    chk_v("R5", 64'h0);
  endtask

  task automatic t_run();
    do_load(64'h0000_0000_0010_0000);
    op = 1'b1;
    tick = 1'b1; cyc();
    chk_v("R2", 64'h0000_0000_000F_F000);
    cyc(); cyc();
    chk_v("R2 idle", 64'h0000_0000_000F_F000);
    tick = 1'b1; cyc();
    tick = 1'b1; cyc();
    chk_v("R2", 64'h0000_0000_000F_D000);
    op = 1'b0;
  endtask

  task automatic t_wait();
    do_load(64'h0000_0000_0000_5000);
    wt = 1'b1; tick = 1'b1; cyc();
    chk_v("R3", 64'h0000_0000_0000_4000);
    wt = 1'b0;
  endtask

  task automatic t_stop();
    do_load(64'h0000_0000_0000_5000);
    op = 1'b1; wt = 1'b1; stp = 1'b1;
    tick = 1'b1; cyc();
    tick = 1'b1; cyc();
    chk_v("R4 stopped", 64'h0000_0000_0000_5000);
    op = 1'b0; wt = 1'b0; stp = 1'b0;
    tick = 1'b1; cyc();
    chk_v("R4 idle cpu", 64'h0000_0000_0000_5000);
  endtask

  task automatic t_collide();
    op = 1'b1;
    ld = 1'b1; ldv = 64'h0000_0000_0007_0000; tick = 1'b1; cyc();
    chk_v("R6", 64'h0000_0000_0007_0000);
    op = 1'b0;
  endtask

  task automatic t_irq();
    do_load(64'h0000_0000_0000_1000);
    emask = 1'b1; smask = 1'b1; op = 1'b1;
    #1 chk_i("R7 pos", 1'b0);
    @(negedge clk);
    tick = 1'b1; cyc();
    chk_v("R7", 64'h0); chk_i("R7 zero", 1'b0);
    tick = 1'b1; cyc();
    chk_v("R7", 64'hFFFF_FFFF_FFFF_F000); chk_i("R7 neg", 1'b1);
    tick = 1'b1; cyc();
    chk_i("R7 level", 1'b1);
    emask = 1'b0; #1 chk_i("R7 ext mask off", 1'b0);
    emask = 1'b1; #1 chk_i("R7 ext mask on", 1'b1);
    smask = 1'b0; #1 chk_i("R7 sub mask off", 1'b0);
    smask = 1'b1; #1 chk_i("R7 sub mask on", 1'b1);
    @(negedge clk);
    op = 1'b0;
  endtask

  task automatic t_cancel();
    do_load(64'h8000_0000_0000_3000);
    chk_i("R7 load neg", 1'b1);
    do_load(64'h0000_0000_0000_5000);
    chk_i("R8", 1'b0);
    chk_v("R8", 64'h0000_0000_0000_5000);
  endtask

  task automatic t_wrap();
    do_load(64'h8000_0000_0000_0000);
    op = 1'b1; tick = 1'b1; cyc();
    chk_v("R9", 64'h7FFF_FFFF_FFFF_F000);
    chk_i("R9", 1'b0);
    op = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_run();
    t_wait();
    t_stop();
    t_collide();
    t_irq();
    t_cancel();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule